// File: doc/BRIEF.md
# Output Port Register with A20 Gate and Reset Request

This block holds the eight-bit output port of a legacy keyboard controller and drives two system lines from it: the A20 address gate and a system reset request. The command decoder next to it passes every byte written to the command register (`cmd_wr`, `cmd_byte`). When the data byte that follows an output-port write command arrives, the decoder also raises a full-port write strobe (`port_wr`, `port_data`). The block decodes the few command bytes it acts on itself. Every other command byte is ignored.

The A20 line is a registered level and always equals bit 1 of the stored port. A reset request is a one-cycle strobe. It comes from a pulse command whose bit 0 is low, or from a full-port write that clears bit 0. On read-back, two bits of the port are not taken from storage. They follow the controller's keyboard and mouse output-buffer-full flags instead.

Top module: `oport_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `port_q` reads 0xCF with both buffer-full flags low, `a20_o` is 1 and `sys_reset_req` is 0.
- R2: A command byte 0xF0–0xFF with bit 0 equal to 0 (0xFE among them) raises `sys_reset_req` in the cycle after the clock edge that samples it. The stored port does not change.
- R3: A command byte 0xF0–0xFF with bit 0 equal to 1 changes neither the port nor either output.
- R4: Command 0xDF sets port bit 1, and `a20_o` reads 1 from the next cycle.
- R5: Command 0xDD clears port bit 1, and `a20_o` reads 0 from the next cycle.
- R6: A full-port write stores the byte. From the next cycle `port_q` shows it (bits 4 and 5 excepted) and `a20_o` equals its bit 1.
- R7: A full-port write whose bit 0 is 0 raises `sys_reset_req` for one cycle. The byte is still stored.
- R8: `port_q` bit 4 equals `kbd_obf` and bit 5 equals `aux_obf` in the same cycle, whatever was stored in those positions.
- R9: Any other command byte (for example 0x20, 0xDE) changes neither the port nor either output.
- R10: When a command and a full-port write arrive in the same cycle, the written byte decides the stored port. `sys_reset_req` is raised if either of them asks for a reset.
- R11: `sys_reset_req` is high for exactly one cycle per triggering cycle. Triggers on consecutive cycles keep it high across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Command byte |
| port_wr | input | 1 | Full output-port write strobe |
| port_data | input | 8 | Byte for a full output-port write |
| kbd_obf | input | 1 | Keyboard output-buffer-full flag |
| aux_obf | input | 1 | Mouse output-buffer-full flag |
| port_q | output | 8 | Output port read-back value |
| a20_o | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters. These are an eight-bit port, the A20 gate on bit 1, the run bit on bit 0, the buffer-full mirrors on bits 4 and 5, and a reset value of 0xCF. With these values every pulse code from 0xF0 to 0xFF and both A20 commands can be driven at the ports. Full writes can place arbitrary bytes in the mirrored positions, so the bench can show that stored bits 4 and 5 never reach the read-back. The same build reaches same-cycle collisions between a command and a port write, and back-to-back reset triggers.

// File: rtl/oport_pkg.sv
package oport_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] OP_GATE_ON  = 8'hDF;
  localparam logic [CMD_W-1:0] OP_GATE_OFF = 8'hDD;
  localparam logic [3:0]       OP_PULSE_NIB = 4'hF;

  typedef struct packed {
    logic gate_set;
    logic gate_clr;
    logic rst_pulse;
  } oport_dec_t;
endpackage

// File: rtl/oport_cmd_dec.sv
module oport_cmd_dec
  import oport_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_byte,
  output oport_dec_t       dec
);
  logic is_pulse;

  always_comb begin
    is_pulse      = (cmd_byte[CMD_W-1 -: 4] == OP_PULSE_NIB);
    dec.gate_set  = cmd_wr && (cmd_byte == OP_GATE_ON);
    dec.gate_clr  = cmd_wr && (cmd_byte == OP_GATE_OFF);
    // only the bit-0 pulse of the pulse family has an effect
    dec.rst_pulse = cmd_wr && is_pulse && !cmd_byte[0];
  end
endmodule

// File: rtl/oport_reg.sv
module oport_reg #(
  parameter int          PORT_W    = 8,
  parameter int          GATE_BIT  = 1,
  parameter int          KOBF_BIT  = 4,
  parameter int          AOBF_BIT  = 5,
  parameter logic [PORT_W-1:0] RST_VAL = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_set,
  input  logic              gate_clr,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_data,
  input  logic              kbd_obf,
  input  logic              aux_obf,
  output logic [PORT_W-1:0] port_q,
  output logic              gate_o
);
  logic [PORT_W-1:0] store_q;
  logic [PORT_W-1:0] store_d;
  logic              store_en;

  always_comb begin
    store_en = port_wr | gate_set | gate_clr;
    store_d  = store_q;
    if (gate_set) store_d[GATE_BIT] = 1'b1;
    if (gate_clr) store_d[GATE_BIT] = 1'b0;
    if (port_wr)  store_d = port_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store_q <= RST_VAL;
    else if (store_en) store_q <= store_d;
  end

  assign gate_o = store_q[GATE_BIT];

  for (genvar i = 0; i < PORT_W; i++) begin : g_rd
    if (i == KOBF_BIT) begin : g_k
      assign port_q[i] = kbd_obf;
    end else if (i == AOBF_BIT) begin : g_a
      assign port_q[i] = aux_obf;
    end else begin : g_s
      assign port_q[i] = store_q[i];
    end
  end

  // R4
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_set && !port_wr) |=> gate_o);
  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_clr && !port_wr) |=> !gate_o);
  // R6
  port_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (gate_o == $past(port_data[GATE_BIT])));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_wr && !gate_set && !gate_clr) |=> $stable(store_q));
endmodule

// File: rtl/oport_rst_pulse.sv
module oport_rst_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rst,
  input  logic port_wr,
  input  logic port_run_bit,
  output logic req_o
);
  logic req_d;

  always_comb begin
    req_d = cmd_rst | (port_wr & ~port_run_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_d;
  end

  // R7
  port_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !port_run_bit) |=> req_o);
endmodule

// File: rtl/oport_ctl.sv
module oport_ctl
  import oport_pkg::*;
#(
  parameter int PORT_W   = CMD_W,
  parameter int GATE_BIT = 1,
  parameter int RUN_BIT  = 0,
  parameter int KOBF_BIT = 4,
  parameter int AOBF_BIT = 5,
  parameter logic [PORT_W-1:0] RST_VAL = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_data,
  input  logic              kbd_obf,
  input  logic              aux_obf,
  output logic [PORT_W-1:0] port_q,
  output logic              a20_o,
  output logic              sys_reset_req
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;
  oport_dec_t        dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  oport_cmd_dec u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .dec      (dec)
  );

  oport_reg #(
    .PORT_W   (PORT_W),
    .GATE_BIT (GATE_BIT),
    .KOBF_BIT (KOBF_BIT),
    .AOBF_BIT (AOBF_BIT),
    .RST_VAL  (RST_VAL)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .gate_set  (dec.gate_set),
    .gate_clr  (dec.gate_clr),
    .port_wr   (port_wr),
    .port_data (port_data),
    .kbd_obf   (kbd_obf),
    .aux_obf   (aux_obf),
    .port_q    (port_q),
    .gate_o    (a20_o)
  );

  oport_rst_pulse u_pulse (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cmd_rst      (dec.rst_pulse),
    .port_wr      (port_wr),
    .port_run_bit (port_data[RUN_BIT]),
    .req_o        (sys_reset_req)
  );

  // R2
  pulse_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_wr && cmd_byte[CMD_W-1 -: 4] == 4'hF && !cmd_byte[0]) |=> sys_reset_req);
  // R11
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cmd_wr && !port_wr) |=> !sys_reset_req);
endmodule

// File: tb/oport_ctl_tb.sv
module oport_ctl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr, port_wr, kbd_obf, aux_obf;
  logic [7:0] cmd_byte, port_data;
  logic [7:0] port_q;
  logic       a20_o, sys_reset_req;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oport_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .port_wr(port_wr), .port_data(port_data), .kbd_obf(kbd_obf),
    .aux_obf(aux_obf), .port_q(port_q), .a20_o(a20_o),
    .sys_reset_req(sys_reset_req)
  );

  typedef struct packed {
    logic       cw;
    logic [7:0] cmd;
    logic       pw;
    logic [7:0] pd;
    logic       ko;
    logic       ao;
    logic [7:0] ep;
    logic       ea;
    logic       er;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd1},  // R1 idle
    '{1'b1, 8'hDD, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCD, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 8'hDF, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 8'hFE, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b1, 4'd2},  // R2
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd11}, // R11
    '{1'b1, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b1, 4'd2},  // R2
    '{1'b1, 8'hF1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 8'hDE, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'hDF, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'hEF, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b1, 8'h20, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 8'h00, 1'b1, 8'h3D, 1'b0, 1'b0, 8'h0D, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 1'b0, 8'h02, 1'b1, 1'b1, 4'd7},  // R7
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'd11}, // R11
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11
    '{1'b1, 8'hDF, 1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 4'd10}, // R10
    '{1'b1, 8'hFE, 1'b1, 8'hC3, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1, 4'd10}, // R10
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0, 4'd10}  // R10
  };

  task automatic chk(input int rq, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic chk_all(input int rq, input logic [7:0] ep, input logic ea,
                         input logic er);
    chk(rq, "port_q", port_q, ep);
    chk(rq, "a20_o", {7'd0, a20_o}, {7'd0, ea});
    chk(rq, "sys_reset_req", {7'd0, sys_reset_req}, {7'd0, er});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; port_wr = 1'b0; cmd_byte = '0;
    port_data = '0; kbd_obf = 1'b0; aux_obf = 1'b0;
    repeat (2) @(negedge clk);
    chk_all(1, 8'hCF, 1'b1, 1'b0); // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all(1, 8'hCF, 1'b1, 1'b0); // R1 after release

    for (int i = 0; i < NV; i++) begin
      cmd_wr = VEC[i].cw; cmd_byte = VEC[i].cmd;
      port_wr = VEC[i].pw; port_data = VEC[i].pd;
      kbd_obf = VEC[i].ko; aux_obf = VEC[i].ao;
      @(posedge clk);
      #(CLK_PERIOD/4);
      cmd_wr = 1'b0; port_wr = 1'b0;
      chk_all(int'(VEC[i].rq), VEC[i].ep, VEC[i].ea, VEC[i].er);
      @(negedge clk);
    end

    // R8: mirrored bits follow flags in the same cycle, no clock edge
    port_data = 8'h30; port_wr = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4); port_wr = 1'b0;
    chk(8, "port_q stored 0x30 flags 00", port_q, 8'h00);
    kbd_obf = 1'b1; #1;
    chk(8, "port_q kbd flag only", port_q, 8'h10);
    kbd_obf = 1'b0; aux_obf = 1'b1; #1;
    chk(8, "port_q aux flag only", port_q, 8'h20);
    aux_obf = 1'b0;
    @(negedge clk);

    // R1: reset in mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    chk_all(1, 8'hCF, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all(1, 8'hCF, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule